// File: doc/BRIEF.md
# External Edge Interrupt Line Controller

This block turns up to eight ports of general-purpose pins into sixteen interrupt lines. Each line picks its pin, at the line's own index, from one of the ports. It synchronizes that pin to the system clock and watches it for a falling edge, a rising edge or both. A chosen edge latches the line's pending flag. A mask bit then decides whether that flag reaches a request output. Lines 0 to 4 each drive a request output of their own. Lines 5 to 9 share one request output, and lines 10 to 15 share another.

Software sets the block up through a small register bus and services it there as well. Four configuration words hold the port-select fields. Separate words hold the mask, the rising-trigger enables and the falling-trigger enables. A pending word is read to find the lines that fired, and writing ones to it clears them. A typical use is a push button with a pull-up resistor: the pin idles high, the line's falling trigger is enabled, and every press gives one pending event.

Top module: `eirq_lines`

## Requirements
- R1: After a synchronous reset, every register reads 0 and every request output is low.
- R2: Line k takes its port from a 4-bit field in configuration word k/4 (addresses 0 to 3), at bits 4*(k%4)+3 down to 4*(k%4). A field value p selects bit k of port p, where port p occupies pins p*16 to p*16+15. For example, line 13 uses bits 7:4 of address 3, and the value 2 picks port C (the third port). Pins of ports that are not selected have no effect on the line.
- R3: When a line's falling-trigger bit is set (address 6, bit k), a high-to-low change on the selected pin sets the line's pending flag.
- R4: When a line's rising-trigger bit is set (address 5, bit k), a low-to-high change sets the pending flag. With both trigger bits set, either edge sets it. With only the other trigger bit set, the edge is ignored.
- R5: A line with neither trigger bit set never becomes pending, whatever its pin does.
- R6: Writing to the pending word (address 7) clears each flag whose data bit is 1 and leaves unchanged each flag whose data bit is 0. Pending flags never clear in any other way except reset.
- R7: If a qualifying edge on a line is detected in the same cycle as a clear write to that line, the flag stays set.
- R8: Pending flags latch whether or not the line is masked. A request output rises only for lines whose mask bit (address 4, bit k) is 1.
- R9: Request outputs `irq_line[4:0]` follow lines 0 to 4 one to one. `irq_grp_a` is the OR of lines 5 to 9, and `irq_grp_b` is the OR of lines 10 to 15. Each output is built from the pending flag AND the mask, and is registered.
- R10: Rewriting a line's port-select field never creates a pending event by itself, even when the old and new pins are at different levels.
- R11: A pin that goes low and stays low gives exactly one pending event. A clear made while the pin is held low is not followed by a new event. The next press after release gives a new event.
- R12: Every register reads back the value last written, with read data valid one clock after the address is applied. Addresses 0 to 3 are the select words, 4 is the mask, 5 is rising, 6 is falling and 7 is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_pins | input | NUM_PORTS*NUM_LINES | Port p pin i at index p*NUM_LINES+i, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| irq_line | output | 5 | Requests of lines 0 to 4 |
| irq_grp_a | output | 1 | Shared request of lines 5 to 9 |
| irq_grp_b | output | 1 | Shared request of lines 10 to 15 |

## Verification
Two functions can land in the same cycle: a software clear of a pending flag and the detection of a new edge on that same line. The bench provokes this by counting registers. It moves a pin two cycles before the write, so that the second synchronizer stage presents the edge in the cycle when the clear strobe is sampled. It then reads the pending word and expects the flag to still be set. A second kind of collision is a port-select rewrite while the old and new pins differ. After the rewrite, the pending word must stay clear.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_SEL0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd4;
  localparam logic [ADDR_W-1:0] A_RISE = 3'd5;
  localparam logic [ADDR_W-1:0] A_FALL = 3'd6;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd7;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge #(
  parameter int NUM_PORTS = 8,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] port_bits,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 sel_chg,
  input  logic                 rise_en,
  input  logic                 fall_en,
  output logic                 evt
);
  logic lvl, prev;

  // field values beyond the port count select a constant low
  always_comb begin
    lvl = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (sel == SEL_W'(p)) lvl = port_bits[p];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  // one cycle after a select rewrite prev still holds the old pin: blank it
  assign evt = !sel_chg && ((rise_en && lvl && !prev) || (fall_en && !lvl && prev));
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4,
  parameter int DATA_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NUM_LINES-1:0]       evt,
  output logic [NUM_LINES*SEL_W-1:0] sel_q,
  output logic [NUM_LINES-1:0]       sel_chg,
  output logic [NUM_LINES-1:0]       mask_q,
  output logic [NUM_LINES-1:0]       rise_q,
  output logic [NUM_LINES-1:0]       fall_q,
  output logic [NUM_LINES-1:0]       pend_q,
  output logic [DATA_W-1:0]          rdata
);
  localparam int LPW       = DATA_W / SEL_W;
  localparam int SEL_WORDS = NUM_LINES / LPW;

  logic [NUM_LINES-1:0] clr, pend_nxt;
  logic [DATA_W-1:0]    rd_mux;

  assign clr      = (we && addr == A_PEND) ? wdata[NUM_LINES-1:0] : '0;
  assign pend_nxt = (pend_q & ~clr) | evt;   // a fresh edge outranks a clear

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < SEL_WORDS; w++)
      if (addr == A_SEL0 + ADDR_W'(w)) rd_mux = sel_q[w*DATA_W +: DATA_W];
    case (addr)
      A_MASK:  rd_mux = DATA_W'(mask_q);
      A_RISE:  rd_mux = DATA_W'(rise_q);
      A_FALL:  rd_mux = DATA_W'(fall_q);
      A_PEND:  rd_mux = DATA_W'(pend_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      sel_chg <= '0;
      mask_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      pend_q  <= '0;
      rdata   <= '0;
    end else begin
      pend_q  <= pend_nxt;
      rdata   <= rd_mux;
      sel_chg <= '0;
      for (int k = 0; k < NUM_LINES; k++) begin
        if (we && addr == A_SEL0 + ADDR_W'(k / LPW)) begin
          sel_q[k*SEL_W +: SEL_W] <= wdata[(k % LPW)*SEL_W +: SEL_W];
          sel_chg[k] <= wdata[(k % LPW)*SEL_W +: SEL_W] != sel_q[k*SEL_W +: SEL_W];
        end
      end
      if (we) begin
        case (addr)
          A_MASK:  mask_q <= wdata[NUM_LINES-1:0];
          A_RISE:  rise_q <= wdata[NUM_LINES-1:0];
          A_FALL:  fall_q <= wdata[NUM_LINES-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eirq_lines.sv
module eirq_lines
  import eirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 8,
  parameter int SEL_W     = 4,
  parameter int DATA_W    = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] gpio_pins,
  input  logic                           reg_we,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  output logic [4:0]                     irq_line,
  output logic                           irq_grp_a,
  output logic                           irq_grp_b
);
  localparam int DIRECT_N = 5;
  localparam int GA_LO    = DIRECT_N;
  localparam int GA_HI    = 9;
  localparam int GB_LO    = GA_HI + 1;
  localparam int GB_HI    = NUM_LINES - 1;

  logic [NUM_PORTS*NUM_LINES-1:0] pins_s;
  logic [NUM_LINES*SEL_W-1:0]     sel_q;
  logic [NUM_LINES-1:0]           sel_chg, mask_q, rise_q, fall_q, pend_q, line_evt, req;

  eirq_sync #(.WIDTH(NUM_PORTS*NUM_LINES), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(gpio_pins), .q(pins_s)
  );

  eirq_regs #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .evt(line_evt), .sel_q(sel_q), .sel_chg(sel_chg), .mask_q(mask_q),
    .rise_q(rise_q), .fall_q(fall_q), .pend_q(pend_q), .rdata(reg_rdata)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic [NUM_PORTS-1:0] col;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
      assign col[p] = pins_s[p*NUM_LINES + k];
    end
    eirq_edge #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_edge (
      .clk(clk), .rst(rst), .port_bits(col), .sel(sel_q[k*SEL_W +: SEL_W]),
      .sel_chg(sel_chg[k]), .rise_en(rise_q[k]), .fall_en(fall_q[k]),
      .evt(line_evt[k])
    );
  end

  assign req = pend_q & mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line  <= '0;
      irq_grp_a <= 1'b0;
      irq_grp_b <= 1'b0;
    end else begin
      irq_line  <= req[DIRECT_N-1:0];
      irq_grp_a <= |req[GA_HI:GA_LO];
      irq_grp_b <= |req[GB_HI:GB_LO];
    end
  end
endmodule

// File: rtl/eirq_lines_chk.sv
module eirq_lines_chk
  import eirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] line_evt,
  input logic [4:0]           irq_line,
  input logic                 irq_grp_a,
  input logic                 irq_grp_b
);
  logic pclr;
  assign pclr = reg_we && reg_addr == A_PEND;

  a_r6_ones_clear: assert property (@(posedge clk) disable iff (rst)
    pclr |=> ((pend_q & $past(reg_wdata[NUM_LINES-1:0] & ~line_evt)) == '0));

  a_r6_no_silent_drop: assert property (@(posedge clk) disable iff (rst)
    !pclr |=> (($past(pend_q) & ~pend_q) == '0));

  a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (line_evt != '0) |=> ((pend_q & $past(line_evt)) == $past(line_evt)));

  a_r5_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '1) |=> ((pend_q & ~$past(pend_q) & ~$past(line_evt)) == '0));

  a_r8_masked_silent: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> (irq_line == '0 && !irq_grp_a && !irq_grp_b));
endmodule

bind eirq_lines eirq_lines_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pend_q(pend_q), .mask_q(mask_q), .line_evt(line_evt), .irq_line(irq_line),
  .irq_grp_a(irq_grp_a), .irq_grp_b(irq_grp_b)
);

// File: tb/sim_eirq_lines.sv
module sim_eirq_lines;
  localparam int NL = 16;
  localparam int NP = 8;
  localparam int NV = 8;
  // entry: line[12:9] port[8:6] rise[5] fall[4] mask[3] dir_up[2] expect[1] spare[0]
  localparam logic [12:0] VEC [NV] = '{
    {4'd13, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 R2 line 13 on port C
    {4'd13, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 wrong edge
    {4'd3,  3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 R9 direct line
    {4'd7,  3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 both edges, group a
    {4'd0,  3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 no trigger
    {4'd11, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R8 masked
    {4'd15, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R9 group b
    {4'd5,  3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}   // R4 rising ignored
  };

  logic clk = 1'b0, rst = 1'b1, we = 1'b0;
  logic [NP*NL-1:0] pins = '0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [4:0]  irq_line;
  logic        irq_grp_a, irq_grp_b;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  eirq_lines u0 (
    .clk(clk), .rst(rst), .gpio_pins(pins), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_line(irq_line),
    .irq_grp_a(irq_grp_a), .irq_grp_b(irq_grp_b)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] irq_bit(input int line);
    if (line < 5)       return 7'(1) << line;
    else if (line < 10) return 7'b0100000;
    else                return 7'b1000000;
  endfunction

  function automatic logic [15:0] sel_word(input int line, input int port);
    return 16'(port) << (4 * (line % 4));
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    tick(3); rst = 1'b0; tick(1);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R1 reg after reset", d, 16'h0);
    end
    chk("R1 irq after reset", {9'd0, irq_grp_b, irq_grp_a, irq_line}, 16'h0);

    // R12 readback
    wr(3'd1, 16'hA5C3); wr(3'd4, 16'h1234); wr(3'd5, 16'h8001); wr(3'd6, 16'h0F0F);
    rd(3'd1, d); chk("R12 sel word 1", d, 16'hA5C3);
    rd(3'd4, d); chk("R12 mask", d, 16'h1234);
    rd(3'd5, d); chk("R12 rise", d, 16'h8001);
    rd(3'd6, d); chk("R12 fall", d, 16'h0F0F);
    wr(3'd1, 16'h0);

    for (int v = 0; v < NV; v++) begin
      int ln, pt, wp, pidx;
      logic up, ex, mk;
      ln = int'(VEC[v][12:9]); pt = int'(VEC[v][8:6]);
      up = VEC[v][2]; ex = VEC[v][1]; mk = VEC[v][3];
      wp = (pt + 1) % NP;
      wr(3'd5, 16'h0); wr(3'd6, 16'h0); wr(3'd4, 16'h0);
      pins = {(NP*NL){~up}}; tick(4);
      wr(3'(ln / 4), sel_word(ln, pt));
      wr(3'd5, {15'd0, VEC[v][5]} << ln);
      wr(3'd6, {15'd0, VEC[v][4]} << ln);
      wr(3'd4, {15'd0, mk} << ln);
      tick(4); wr(3'd7, 16'hFFFF); tick(2);
      pins[wp*NL + ln] = up; tick(6);
      rd(3'd7, d); chk("R2 unselected port ignored", d, 16'h0);
      pidx = pt*NL + ln;
      pins[pidx] = up; tick(6);
      rd(3'd7, d); chk("R3/R4/R5 pending after edge", d, {15'd0, ex} << ln);
      chk("R8/R9 request outputs", {9'd0, irq_grp_b, irq_grp_a, irq_line},
          {9'd0, (ex && mk) ? irq_bit(ln) : 7'd0});
      wr(3'd0 + 3'(ln / 4), 16'h0);
    end

    // R7 and R6 on line 2, port 0, falling
    wr(3'd5, 16'h0); wr(3'd6, 16'h0004); wr(3'd4, 16'h0004);
    pins = '1; tick(4); wr(3'd7, 16'hFFFF);
    pins[2] = 1'b0; tick(6); pins[2] = 1'b1; tick(6);
    rd(3'd7, d); chk("R3 line 2 first event", d, 16'h0004);
    tick(1); pins[2] = 1'b0; tick(1);
    wr(3'd7, 16'h0004);
    rd(3'd7, d); chk("R7 edge with clear keeps flag", d, 16'h0004);
    wr(3'd7, 16'h0000);
    rd(3'd7, d); chk("R6 writing zero keeps flag", d, 16'h0004);
    wr(3'd7, 16'h0004);
    rd(3'd7, d); chk("R6 writing one clears flag", d, 16'h0000);
    chk("R9 irq low after clear", {11'd0, irq_line}, 16'h0);

    // R11 button on line 13, port C, pulled high
    wr(3'd6, 16'h2000); wr(3'd4, 16'h2000); wr(3'd3, 16'h0020);
    pins = '1; tick(6); wr(3'd7, 16'hFFFF);
    pins[2*NL+13] = 1'b0; tick(12);
    rd(3'd7, d); chk("R11 one event on press", d, 16'h2000);
    chk("R9 group b request", {15'd0, irq_grp_b}, 16'h1);
    wr(3'd7, 16'h2000); tick(12);
    rd(3'd7, d); chk("R11 no new event while held", d, 16'h0);
    pins[2*NL+13] = 1'b1; tick(8);
    rd(3'd7, d); chk("R11 release gives no event", d, 16'h0);
    pins[2*NL+13] = 1'b0; tick(8);
    rd(3'd7, d); chk("R11 second press", d, 16'h2000);

    // R10 select change with differing levels
    wr(3'd5, 16'h2000); wr(3'd6, 16'h2000);
    pins = '0; pins[2*NL+13] = 1'b1; tick(6); wr(3'd7, 16'hFFFF); tick(2);
    wr(3'd3, 16'h0000); tick(8);
    rd(3'd7, d); chk("R10 no event from select rewrite", d, 16'h0);
    pins[13] = 1'b1; tick(6);
    rd(3'd7, d); chk("R10 new port still detects", d, 16'h2000);

    finish_run();
  end
endmodule